// File: doc/BRIEF.md
# Receive descriptor ring writeback engine

This block moves received frames from a byte-wide receive stream into host memory. The host prepares a circular list of 16-byte receive descriptors in memory. Each descriptor holds a status word, a control word carrying the buffer size and a wrap flag, and a buffer pointer. The engine reads a descriptor and checks that the host has handed it over. It then stores the incoming frame into that buffer, one 32-bit word at a time with byte enables. Once every data write has been issued, it writes a status word back to the descriptor, which returns the descriptor to the host.

Software starts and stops the engine with a single run input and supplies the ring base address. A 3-bit process-state output shows what the engine is doing. When the next descriptor still belongs to the host, the engine discards the whole incoming frame, pulses a drop flag and polls the descriptor again. A frame that is longer than its buffer is cut at the buffer size and flagged. A frame always occupies exactly one descriptor.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset, rx_state is 0 (stopped), rx_ready is low and no memory request is issued.
- R2: When run is raised from the stopped state, the engine reads the descriptor at the ring base in this order: status (+0), control (+4), buffer pointer (+8). rx_state is 1 while a descriptor is being fetched.
- R3: A descriptor whose status bit 31 (ownership) is clear gets no data written to it. The engine enters state 4, accepts and discards every byte of an arriving frame, pulses rx_drop once after the frame's last byte, and then reads the same descriptor again.
- R4: Frame byte n is written to buffer address + n (byte lane n mod 4, little-endian). Writes are word-aligned 32-bit accesses, and only the lanes that carry frame bytes are enabled.
- R5: The buffer size comes from control bits 10:0. Bytes beyond that size are never written, and the error-summary bit is set.
- R6: The status writeback puts 0 in bit 31, the frame length in bits 30:16 (every byte, including the 4-byte FCS, saturating at 32767), error summary in bit 15, and 1 in bit 8 (last descriptor). All other bits are 0.
- R7: rx_err asserted with a frame's last byte sets the error-summary bit.
- R8: The status write for a descriptor comes after every data write of its frame.
- R9: After a writeback, the next descriptor is at the current address + 16, or at the ring base when control bit 25 (end of ring) is set.
- R10: Dropping run takes effect at a frame boundary, and the engine goes to state 0. A restart always begins at the ring base.
- R11: rx_ready is high exactly in states 2 (owned descriptor waiting), 3 (frame in progress) and 4 (no buffer). State 5 marks the status writeback.
- R12: With a buffer size of 0, a frame causes no data write at all and is reported with error summary set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_run | input | 1 | Start (1) / stop (0) of the receive process |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_err | input | 1 | Frame error, sampled with the last byte |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_drop | output | 1 | One-cycle pulse: a frame was discarded for lack of a buffer |
| rx_state | output | 3 | Process state code |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid, one cycle after the read request |

## Verification
The hardest situations to reach from the ports are a frame arriving while the engine is suspended on a descriptor the host has not released, and a ring wrap that lands on a descriptor which has just been written back. The bench makes the last prepared descriptor unowned, which starves the engine, and sends a frame into that gap. It then hands the descriptor over during the polling loop, so that the following wrap finds the first descriptor already returned. A 40000-byte frame into a zero-size buffer covers length saturation without a single data write.

// File: rtl/rxr_pkg.sv
// Shared types and descriptor field positions for the receive ring engine.
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_STOP  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_STORE = 3'd3,
        ST_SUSP  = 3'd4,
        ST_CLOSE = 3'd5
    } rxr_state_e;

    localparam int OWN_BIT    = 31;
    localparam int WRAP_BIT   = 25;
    localparam int ES_BIT     = 15;
    localparam int LAST_BIT   = 8;
    localparam int DESC_BYTES = 16;

    // Build the status word returned to the host.
    function automatic logic [31:0] make_status(input logic [14:0] len, input logic es);
        logic [31:0] w;
        w = '0;
        w[30:16] = len;
        w[ES_BIT] = es;
        w[LAST_BIT] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/rxr_ctrl.sv
// Descriptor sequencer: fetches descriptors, gates the receive stream,
// writes the status word back and advances or wraps the ring pointer.
// Assumes one read in flight at a time and rd_valid one cycle after issue.
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] ring_base,
    input  logic          rx_valid,
    input  logic          rx_last,
    input  logic          rd_valid,
    input  logic [31:0]   rd_data,
    input  logic [14:0]   frame_len,
    input  logic          frame_es,
    output rxr_state_e    state,
    output logic          rx_ready,
    output logic          accept,
    output logic          pk_clr,
    output logic [SW-1:0] buf_size,
    output logic [AW-1:0] buf_addr,
    output logic          ct_req,
    output logic          ct_we,
    output logic [AW-1:0] ct_addr,
    output logic [31:0]   ct_wdata,
    output logic          drop_pulse
);
    logic [AW-1:0] ptr;
    logic [1:0]    fidx;
    logic          pend;
    logic          own_q;
    logic          wrap_q;
    logic [AW-1:0] bufp_q;
    logic          drop_mid;
    logic          in_frame_st;

    // Stream gating derived from the state.
    always_comb begin
        in_frame_st = (state == ST_WAIT) || (state == ST_STORE);
        rx_ready    = in_frame_st || (state == ST_SUSP);
        accept      = rx_valid && in_frame_st;
        pk_clr      = !in_frame_st;
        buf_size    = buf_size_q;
        buf_addr    = {bufp_q[AW-1:2], 2'b00};
    end

    logic [SW-1:0] buf_size_q;

    // Memory request for descriptor reads and the status writeback.
    always_comb begin
        ct_req   = ((state == ST_FETCH) && !pend) || (state == ST_CLOSE);
        ct_we    = (state == ST_CLOSE);
        ct_addr  = (state == ST_CLOSE) ? ptr : ptr + AW'({fidx, 2'b00});
        ct_wdata = make_status(frame_len, frame_es);
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_STOP;
            ptr        <= '0;
            fidx       <= '0;
            pend       <= 1'b0;
            own_q      <= 1'b0;
            wrap_q     <= 1'b0;
            bufp_q     <= '0;
            buf_size_q <= '0;
            drop_mid   <= 1'b0;
        end else begin
            case (state)
                ST_STOP: begin
                    ptr  <= ring_base;
                    fidx <= '0;
                    pend <= 1'b0;
                    if (run) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (pend && rd_valid) begin
                        pend <= 1'b0;
                        case (fidx)
                            2'd0: begin
                                own_q <= rd_data[OWN_BIT];
                                if (rd_data[OWN_BIT]) fidx <= 2'd1;
                                else state <= ST_SUSP;
                            end
                            2'd1: begin
                                buf_size_q <= rd_data[SW-1:0];
                                wrap_q     <= rd_data[WRAP_BIT];
                                fidx       <= 2'd2;
                            end
                            default: begin
                                bufp_q <= rd_data[AW-1:0];
                                fidx   <= 2'd0;
                                state  <= ST_WAIT;
                            end
                        endcase
                    end else if (!pend) begin
                        pend <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (accept) state <= rx_last ? ST_CLOSE : ST_STORE;
                    else if (!run) state <= ST_STOP;
                end
                ST_STORE: begin
                    if (accept && rx_last) state <= ST_CLOSE;
                end
                ST_CLOSE: begin
                    ptr   <= wrap_q ? ring_base : ptr + AW'(DESC_BYTES);
                    fidx  <= '0;
                    own_q <= 1'b0;
                    state <= run ? ST_FETCH : ST_STOP;
                end
                ST_SUSP: begin
                    if (rx_valid) begin
                        if (rx_last) begin
                            drop_mid <= 1'b0;
                            state    <= run ? ST_FETCH : ST_STOP;
                        end else begin
                            drop_mid <= 1'b1;
                        end
                    end else if (!drop_mid) begin
                        state <= run ? ST_FETCH : ST_STOP;
                    end
                end
                default: state <= ST_STOP;
            endcase
        end
    end

    // One-cycle flag after a discarded frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_pulse <= 1'b0;
        else        drop_pulse <= (state == ST_SUSP) && rx_valid && rx_last;
    end

    p_close_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && rx_last |=> state == ST_CLOSE);
    p_drop_leaves_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> (state == ST_FETCH) || (state == ST_STOP));
    p_owned_before_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_st |-> own_q);
    p_wrap_to_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE) && wrap_q |=> ptr == $past(ring_base));
    p_step_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE) && !wrap_q |=> ptr == $past(ptr) + AW'(DESC_BYTES));
    p_stop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) && !run |=> state == ST_STOP);
endmodule

// File: rtl/rxr_packer.sv
// Byte-to-word packer: places frame bytes in little-endian lanes, limits
// stores to the buffer size and keeps the frame length and error summary.
// Assumes the buffer pointer is word aligned; cleared between frames.
module rxr_packer #(
    parameter int AW = 32,
    parameter int SW = 11,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          accept,
    input  logic [7:0]    byte_in,
    input  logic          last,
    input  logic          err,
    input  logic [SW-1:0] buf_size,
    input  logic [AW-1:0] buf_addr,
    output logic          pk_req,
    output logic [AW-1:0] pk_addr,
    output logic [31:0]   pk_wdata,
    output logic [3:0]    pk_be,
    output logic [14:0]   frame_len,
    output logic          frame_es
);
    localparam logic [CW-1:0] LEN_CAP = CW'(32767);

    logic [CW-1:0] cnt;
    logic [31:0]   wacc;
    logic [3:0]    bacc;
    logic          trunc;
    logic          errf;
    logic [1:0]    lane;
    logic          in_buf;
    logic          flush;
    logic [CW-1:0] size_ext;
    logic [31:0]   word_n;
    logic [3:0]    be_n;

    // Merge the incoming byte into its lane.
    always_comb begin
        lane     = cnt[1:0];
        size_ext = CW'(buf_size);
        in_buf   = cnt < size_ext;
        flush    = (lane == 2'd3) || last || ((cnt + CW'(1)) == size_ext);
        word_n   = wacc;
        be_n     = bacc;
        for (int l = 0; l < 4; l++) begin
            if (lane == 2'(l)) begin
                word_n[8*l +: 8] = byte_in;
                be_n[l]          = 1'b1;
            end
        end
    end

    // Word write request toward the memory port.
    always_comb begin
        pk_req    = accept && in_buf && flush;
        pk_addr   = buf_addr + AW'({cnt[CW-1:2], 2'b00});
        pk_wdata  = word_n;
        pk_be     = be_n;
        frame_len = (cnt > LEN_CAP) ? 15'h7FFF : cnt[14:0];
        frame_es  = trunc || errf;
    end

    // Byte count, partial word and error tracking for one frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt   <= '0;
            wacc  <= '0;
            bacc  <= '0;
            trunc <= 1'b0;
            errf  <= 1'b0;
        end else if (accept) begin
            cnt <= (&cnt) ? cnt : cnt + CW'(1);
            if (in_buf) begin
                if (flush) begin
                    wacc <= '0;
                    bacc <= '0;
                end else begin
                    wacc <= word_n;
                    bacc <= be_n;
                end
            end else begin
                trunc <= 1'b1;
            end
            if (last && err) errf <= 1'b1;
        end
    end

    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pk_req |-> pk_addr[1:0] == 2'b00);
    p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !accept |=> $stable(cnt));
    p_trunc_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trunc && !clr |=> trunc);
endmodule

// File: rtl/rxr_port.sv
// Memory port register: merges packer writes and sequencer accesses into
// one registered request. Assumes the memory accepts every request.
module rxr_port #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pk_req,
    input  logic [AW-1:0] pk_addr,
    input  logic [31:0]   pk_wdata,
    input  logic [3:0]    pk_be,
    input  logic          ct_req,
    input  logic          ct_we,
    input  logic [AW-1:0] ct_addr,
    input  logic [31:0]   ct_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be
);
    // Register the selected request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
        end else begin
            mem_req <= pk_req || ct_req;
            if (pk_req) begin
                mem_we    <= 1'b1;
                mem_addr  <= pk_addr;
                mem_wdata <= pk_wdata;
                mem_be    <= pk_be;
            end else begin
                mem_we    <= ct_we;
                mem_addr  <= ct_addr;
                mem_wdata <= ct_wdata;
                mem_be    <= ct_we ? 4'hF : 4'h0;
            end
        end
    end

    p_one_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pk_req && ct_req));
endmodule

// File: rtl/rx_ring_dma.sv
// Top of the receive descriptor ring engine: sequencer, packer and
// memory port register. Memory has fixed one-cycle read latency, no stall.
module rx_ring_dma
    import rxr_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 11,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_run,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_err,
    output logic          rx_ready,
    output logic          rx_drop,
    output logic [2:0]    rx_state,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rvalid
);
    rxr_state_e    state;
    logic          accept, pk_clr;
    logic [SW-1:0] buf_size;
    logic [AW-1:0] buf_addr;
    logic          ct_req, ct_we;
    logic [AW-1:0] ct_addr;
    logic [31:0]   ct_wdata;
    logic          pk_req;
    logic [AW-1:0] pk_addr;
    logic [31:0]   pk_wdata;
    logic [3:0]    pk_be;
    logic [14:0]   frame_len;
    logic          frame_es;

    assign rx_state = state;

    rxr_ctrl #(.AW(AW), .SW(SW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(cfg_run), .ring_base(cfg_ring_base),
        .rx_valid(rx_valid), .rx_last(rx_last),
        .rd_valid(mem_rvalid), .rd_data(mem_rdata),
        .frame_len(frame_len), .frame_es(frame_es),
        .state(state), .rx_ready(rx_ready), .accept(accept), .pk_clr(pk_clr),
        .buf_size(buf_size), .buf_addr(buf_addr),
        .ct_req(ct_req), .ct_we(ct_we), .ct_addr(ct_addr), .ct_wdata(ct_wdata),
        .drop_pulse(rx_drop)
    );

    rxr_packer #(.AW(AW), .SW(SW), .CW(CW)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .accept(accept),
        .byte_in(rx_data), .last(rx_last), .err(rx_err),
        .buf_size(buf_size), .buf_addr(buf_addr),
        .pk_req(pk_req), .pk_addr(pk_addr), .pk_wdata(pk_wdata), .pk_be(pk_be),
        .frame_len(frame_len), .frame_es(frame_es)
    );

    rxr_port #(.AW(AW)) u_port (
        .clk(clk), .rst_n(rst_n),
        .pk_req(pk_req), .pk_addr(pk_addr), .pk_wdata(pk_wdata), .pk_be(pk_be),
        .ct_req(ct_req), .ct_we(ct_we), .ct_addr(ct_addr), .ct_wdata(ct_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be)
    );
endmodule

// File: tb/rx_ring_dma_test.sv
module rx_ring_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_run = 1'b0;
    logic [31:0] cfg_ring_base = 32'h100;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_ready, rx_drop;
    logic [2:0]  rx_state;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_rvalid = 1'b0;

    always #10 clk = ~clk;

    rx_ring_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_ring_base(cfg_ring_base),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready), .rx_drop(rx_drop), .rx_state(rx_state),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // Behavioural model state: memory image, expected bytes, permissions.
    logic [31:0] mem [0:1023];
    logic [7:0]  expb [0:4095];
    bit          allow [0:4095];
    int          pend_bytes = 0;
    int          n_chk = 0, n_fail = 0, drops = 0, cyc = 0;
    bit          done = 1'b0;
    logic [31:0] rd_q [$];
    logic [31:0] last_rd = 32'h0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'(seed * 37 + i * 13 + 5);
    endfunction

    function automatic logic [31:0] status_of(input int len, input bit es);
        int l;
        l = (len > 32767) ? 32767 : len;
        return (32'(l) << 16) | (32'(es) << 15) | 32'h100;
    endfunction

    function automatic int count_allow();
        int c = 0;
        for (int a = 0; a < 4096; a++) if (allow[a]) c++;
        return c;
    endfunction

    // Memory, per-clock write comparison and ready/state check.
    always @(negedge clk) begin
        cyc++;
        mem_rvalid = 1'b0;
        if (rst_n) begin
            chk(rx_ready == (rx_state == 3'd2 || rx_state == 3'd3 || rx_state == 3'd4),
                "R11 ready vs state", {29'd0, rx_state}, {31'd0, rx_ready});
            if (mem_req && mem_we) begin
                if (mem_addr < 32'h200 && mem_addr + 3 < 32'h200)
                    chk(pend_bytes == 0, "R8 status after data", 32'(pend_bytes), 32'd0);
                for (int b = 0; b < 4; b++) begin
                    if (mem_be[b]) begin
                        int a;
                        a = int'(mem_addr) + b;
                        if (a >= 4096) begin
                            chk(1'b0, "R4/R5 write address range", 32'(a), 32'd0);
                        end else begin
                            chk(allow[a] && mem_wdata[8*b +: 8] == expb[a],
                                (a < 'h200) ? "R6 status byte" : "R4/R5 data byte",
                                {24'd0, mem_wdata[8*b +: 8]}, {24'd0, expb[a]});
                            if (allow[a]) begin
                                allow[a] = 1'b0;
                                if (a >= 'h200) pend_bytes--;
                            end
                            mem[a >> 2][8*b +: 8] = mem_wdata[8*b +: 8];
                        end
                    end
                end
            end else if (mem_req) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[mem_addr[11:2]];
                rd_q.push_back(mem_addr);
                last_rd = mem_addr;
            end
            if (rx_drop) drops++;
        end
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic set_desc(input int d, input bit own, input int size, input bit wrap, input int bufp);
        mem[(d + 4) >> 2] = (32'(wrap) << 25) | 32'(size);
        mem[(d + 8) >> 2] = 32'(bufp);
        mem[d >> 2]       = 32'(own) << 31;
    endtask

    task automatic expect_data(input int bufp, input int size, input int n, input int seed);
        for (int i = 0; i < n && i < size; i++) begin
            expb[bufp + i]  = byte_of(seed, i);
            allow[bufp + i] = 1'b1;
            pend_bytes++;
        end
    endtask

    task automatic expect_status(input int d, input int len, input bit es);
        logic [31:0] v;
        v = status_of(len, es);
        for (int b = 0; b < 4; b++) begin
            expb[d + b]  = v[8*b +: 8];
            allow[d + b] = 1'b1;
        end
    endtask

    task automatic send_frame(input int n, input int seed, input bit err, input bit chk3);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (chk3 && i == 1) chk(rx_state == 3'd3, "R11 state 3 mid-frame", {29'd0, rx_state}, 32'd3);
            rx_valid = 1'b1;
            rx_data  = byte_of(seed, i);
            rx_last  = (i == n - 1);
            rx_err   = err && (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic wait_state(input logic [2:0] s, input string req);
        int t = 0;
        while (rx_state != s && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(rx_state == s, req, {29'd0, rx_state}, {29'd0, s});
    endtask

    initial begin
        int d0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        for (int a = 0; a < 4096; a++) begin
            expb[a]  = 8'h0;
            allow[a] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_state == 3'd0, "R1 reset state", {29'd0, rx_state}, 32'd0);
        chk(rx_ready == 1'b0, "R1 ready low", {31'd0, rx_ready}, 32'd0);
        chk(mem_req == 1'b0, "R1 no request", {31'd0, mem_req}, 32'd0);

        set_desc('h100, 1, 64, 0, 'h400);
        set_desc('h110, 1, 5, 0, 'h500);
        set_desc('h120, 1, 16, 0, 'h600);
        set_desc('h130, 0, 0, 1, 'h680);
        cfg_run = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(rx_state == 3'd1, "R2 fetch state", {29'd0, rx_state}, 32'd1);
        wait_state(3'd2, "R2 owned descriptor waiting");
        chk(rd_q.size() >= 3 && rd_q[0] == 32'h100, "R2 read status first", rd_q[0], 32'h100);
        chk(rd_q.size() >= 3 && rd_q[1] == 32'h104, "R2 read control second", rd_q[1], 32'h104);
        chk(rd_q.size() >= 3 && rd_q[2] == 32'h108, "R2 read pointer third", rd_q[2], 32'h108);

        // R4, R6: ten bytes, partial last word.
        expect_data('h400, 64, 10, 1);
        expect_status('h100, 10, 0);
        send_frame(10, 1, 0, 1);
        wait_state(3'd2, "R9 next descriptor fetched");
        chk(count_allow() == 0, "R4 R6 frame stored and closed", 32'(count_allow()), 32'd0);

        // R5: truncation to five bytes.
        expect_data('h500, 5, 7, 2);
        expect_status('h110, 7, 1);
        send_frame(7, 2, 0, 0);
        wait_state(3'd2, "R9 third descriptor fetched");
        chk(count_allow() == 0, "R5 truncated frame", 32'(count_allow()), 32'd0);

        // R7: error on last byte.
        expect_data('h600, 16, 3, 3);
        expect_status('h120, 3, 1);
        send_frame(3, 3, 1, 0);
        wait_state(3'd4, "R3 unowned descriptor suspends");
        chk(count_allow() == 0, "R7 error frame", 32'(count_allow()), 32'd0);

        // R3: frame dropped while suspended.
        d0 = drops;
        send_frame(6, 4, 0, 0);
        repeat (3) @(negedge clk);
        chk(drops == d0 + 1, "R3 one drop pulse", 32'(drops), 32'(d0 + 1));
        chk(rx_state == 3'd4 || rx_state == 3'd1, "R3 still polling", {29'd0, rx_state}, 32'd4);
        chk(last_rd == 32'h130, "R3 rereads same descriptor", last_rd, 32'h130);

        // R12, R6 saturation, R9 wrap.
        set_desc('h130, 1, 0, 1, 'h680);
        wait_state(3'd2, "R3 released descriptor taken");
        expect_status('h130, 40000, 1);
        send_frame(40000, 5, 0, 0);
        wait_state(3'd4, "R9 wrapped onto returned descriptor");
        chk(count_allow() == 0, "R12 zero-size status only", 32'(count_allow()), 32'd0);
        chk(last_rd == 32'h100, "R9 wrap to base", last_rd, 32'h100);

        // R10: stop and restart.
        cfg_run = 1'b0;
        wait_state(3'd0, "R10 stop while suspended");
        chk(rx_ready == 1'b0, "R10 not ready when stopped", {31'd0, rx_ready}, 32'd0);
        set_desc('h100, 1, 64, 0, 'h700);
        cfg_run = 1'b1;
        wait_state(3'd2, "R10 restart fetch");
        expect_data('h700, 64, 4, 6);
        expect_status('h100, 4, 0);
        send_frame(4, 6, 0, 1);
        wait_state(3'd4, "R9 stepped to returned descriptor");
        chk(last_rd == 32'h110, "R9 step by 16", last_rd, 32'h110);
        chk(count_allow() == 0, "R4 full word frame", 32'(count_allow()), 32'd0);
        cfg_run = 1'b0;
        wait_state(3'd0, "R10 stopped again");
        rd_q.delete();
        cfg_run = 1'b1;
        wait_state(3'd4, "R10 restart suspends");
        chk(rd_q.size() > 0 && rd_q[0] == 32'h100, "R10 restart at base", rd_q[0], 32'h100);
        cfg_run = 1'b0;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule